// File: doc/BRIEF.md
# Condition Register Field Unit

This block is a purely combinational execution stage that works on a 32-bit condition register. The register is divided into eight 4-bit fields. The stage performs four kinds of operation:

- a masked move of a general operand into selected fields;
- a read of the register into a general result, either the whole register or a single field;
- a copy of one field onto another;
- a two-input logical function on two single condition bits, written into a third bit.

There are three outputs: a general result, the new value of the one condition field that changed, and the full condition register after the operation. Each output has its own valid flag. A flag is raised only by the operations that really produce that output, because the surrounding pipeline turns these flags directly into register-file write requests. The operation code and the raw instruction word travel through unchanged, so later stages see the same context.

Architectural field and bit numbers count from the most significant end. Field number k lives at slice 7-k, meaning bits 4(7-k)+3 down to 4(7-k). Condition bit k lives at bit 31-k. The field mask is the exception: mask bit i selects slice i, bits 4i+3 down to 4i.

Top module: `cr_field_unit`

## Requirements
- R1: Operation codes on `opCode` are 3'd1 masked move, 3'd2 read register, 3'd3 field copy and 3'd4 bit logic. Every other code performs no operation.
- R2: For a masked move, each slice i with `fieldMask[i]` set takes bits 4i+3:4i of `operandA`. Every other slice of `fullCrOut` equals `crIn`.
- R3: For a read register with `insnWord[20]` = 0, `resultOut` equals `crIn`.
- R4: For a read register with `insnWord[20]` = 1 and exactly one bit i of `fieldMask` set, `resultOut` holds slice i of `crIn` in place and zeros elsewhere. With zero or several mask bits set, `resultOut` is all zeros.
- R5: For a field copy, slice 7-`dstField` of `fullCrOut` equals slice 7-`srcField` of `crIn`, and every other slice equals `crIn`. `condFieldOut` carries the copied value.
- R6: For bit logic, bit 31-`bitT` of `fullCrOut` equals `truthTab[2*a+b]`, where a is bit 31-`bitA` of `crIn` and b is bit 31-`bitB` of `crIn`. All other bits equal `crIn`. `condFieldOut` equals slice 7-`bitT[4:2]` of `fullCrOut`.
- R7: `resultValid` is high only for read register. `fullCrValid` is high only for masked move, field copy and bit logic. `condValid` is high only for field copy and bit logic.
- R8: Whenever an output's valid flag is low, that data output is all zeros.
- R9: `opCodeOut` and `insnWordOut` equal `opCode` and `insnWord` at all times.
- R10: The stage holds no state. Every output reflects the current inputs in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opCode | input | 3 | Operation code |
| insnWord | input | 32 | Raw instruction word; bit 20 selects the one-field read |
| operandA | input | 32 | General operand for the masked move |
| crIn | input | 32 | Current condition register |
| fieldMask | input | 8 | Field select mask, bit i for slice i |
| dstField | input | 3 | Destination field number for the copy |
| srcField | input | 3 | Source field number for the copy |
| bitT | input | 5 | Target condition bit number |
| bitA | input | 5 | First source condition bit number |
| bitB | input | 5 | Second source condition bit number |
| truthTab | input | 4 | Truth table indexed by {a,b} |
| opCodeOut | output | 3 | Operation code passed through |
| insnWordOut | output | 32 | Instruction word passed through |
| resultOut | output | 32 | General result |
| resultValid | output | 1 | General result is produced |
| condFieldOut | output | 4 | New value of the changed field |
| condValid | output | 1 | Field result is produced |
| fullCrOut | output | 32 | Full condition register after the operation |
| fullCrValid | output | 1 | Full register result is produced |

## Verification
Every result is due zero cycles after its stimulus, because no register lies between the inputs and any output. The bench therefore applies each new input set just after a rising edge and samples all outputs 2 ns later, well before the next edge, against a behavioural model built from bit and field loops. Directed cases cover these corners:

- empty and full masks;
- one-field reads with zero or two mask bits set;
- a copy onto the same field;
- a target bit that is also a source bit;
- the unused codes.

Random cases cover the remaining input space.

// File: rtl/cr_field_unit_pkg.sv
package cr_field_unit_pkg;
  localparam int FIELD_BITS = 4;
  localparam int NUM_FIELDS = 8;
  localparam int CR_BITS    = FIELD_BITS * NUM_FIELDS;
  localparam int FIDX_W     = $clog2(NUM_FIELDS);
  localparam int BIDX_W     = $clog2(CR_BITS);
  localparam int OP_W       = 3;
  localparam int INSN_W     = 32;
  localparam int ONE_FIELD_BIT = 20;

  typedef enum logic [OP_W-1:0] {
    OP_NONE      = 3'd0,
    OP_MOVE_TO   = 3'd1,
    OP_READ_CR   = 3'd2,
    OP_FIELD_CPY = 3'd3,
    OP_BIT_LOGIC = 3'd4
  } crOp_e;

  typedef struct packed {
    logic moveTo;
    logic readWhole;
    logic readOne;
    logic fieldCopy;
    logic bitLogic;
    logic wrResult;
    logic wrCond;
    logic wrFull;
  } crStrobe_t;
endpackage

// File: rtl/cr_field_ctrl.sv
module cr_field_ctrl
  import cr_field_unit_pkg::*;
(
  input  logic [OP_W-1:0]   opCode,
  input  logic [INSN_W-1:0] insnWord,
  output crStrobe_t         strobe
);
  always_comb begin
    strobe = '0;
    unique case (opCode)
      OP_MOVE_TO: begin
        strobe.moveTo = 1'b1;
        strobe.wrFull = 1'b1;
      end
      OP_READ_CR: begin
        strobe.readOne   = insnWord[ONE_FIELD_BIT];
        strobe.readWhole = ~insnWord[ONE_FIELD_BIT];
        strobe.wrResult  = 1'b1;
      end
      OP_FIELD_CPY: begin
        strobe.fieldCopy = 1'b1;
        strobe.wrCond    = 1'b1;
        strobe.wrFull    = 1'b1;
      end
      OP_BIT_LOGIC: begin
        strobe.bitLogic = 1'b1;
        strobe.wrCond   = 1'b1;
        strobe.wrFull   = 1'b1;
      end
      default: strobe = '0;
    endcase
  end
endmodule

// File: rtl/cr_field_dp.sv
module cr_field_dp
  import cr_field_unit_pkg::*;
(
  input  crStrobe_t               strobe,
  input  logic [CR_BITS-1:0]      operandA,
  input  logic [CR_BITS-1:0]      crIn,
  input  logic [NUM_FIELDS-1:0]   fieldMask,
  input  logic [FIDX_W-1:0]       dstField,
  input  logic [FIDX_W-1:0]       srcField,
  input  logic [BIDX_W-1:0]       bitT,
  input  logic [BIDX_W-1:0]       bitA,
  input  logic [BIDX_W-1:0]       bitB,
  input  logic [3:0]              truthTab,
  output logic [CR_BITS-1:0]      resultOut,
  output logic [FIELD_BITS-1:0]   condFieldOut,
  output logic [CR_BITS-1:0]      fullCrOut
);
  logic [CR_BITS-1:0]    movedCr;
  logic [CR_BITS-1:0]    oneFieldRes;
  logic [CR_BITS-1:0]    copiedCr;
  logic [CR_BITS-1:0]    logicCr;
  logic [FIDX_W:0]       maskCount;
  logic                  maskSingle;
  logic [FIDX_W-1:0]     dstSlice;
  logic [FIDX_W-1:0]     srcSlice;
  logic [FIDX_W-1:0]     bitSlice;
  logic [BIDX_W-1:0]     posT;
  logic [BIDX_W-1:0]     posA;
  logic [BIDX_W-1:0]     posB;
  logic                  aVal;
  logic                  bVal;
  logic                  newBit;
  logic [FIELD_BITS-1:0] copyField;

  // per-slice masked move and single-field read
  for (genvar f = 0; f < NUM_FIELDS; f++) begin : g_slice
    assign movedCr[f*FIELD_BITS +: FIELD_BITS] =
      fieldMask[f] ? operandA[f*FIELD_BITS +: FIELD_BITS]
                   : crIn[f*FIELD_BITS +: FIELD_BITS];
    assign oneFieldRes[f*FIELD_BITS +: FIELD_BITS] =
      (fieldMask[f] && maskSingle) ? crIn[f*FIELD_BITS +: FIELD_BITS]
                                   : '0;
  end

  always_comb begin
    maskCount = '0;
    for (int i = 0; i < NUM_FIELDS; i++) begin
      maskCount = maskCount + {{FIDX_W{1'b0}}, fieldMask[i]};
    end
  end
  assign maskSingle = (maskCount == (FIDX_W+1)'(1));

  // field copy, architectural numbering reversed
  assign dstSlice  = FIDX_W'(NUM_FIELDS-1) - dstField;
  assign srcSlice  = FIDX_W'(NUM_FIELDS-1) - srcField;
  assign copyField = crIn[srcSlice*FIELD_BITS +: FIELD_BITS];

  always_comb begin
    copiedCr = crIn;
    copiedCr[dstSlice*FIELD_BITS +: FIELD_BITS] = copyField;
  end

  // bit logic through a truth table
  assign posT   = BIDX_W'(CR_BITS-1) - bitT;
  assign posA   = BIDX_W'(CR_BITS-1) - bitA;
  assign posB   = BIDX_W'(CR_BITS-1) - bitB;
  assign aVal   = crIn[posA];
  assign bVal   = crIn[posB];
  assign newBit = truthTab[{aVal, bVal}];
  assign bitSlice = FIDX_W'(NUM_FIELDS-1) - bitT[BIDX_W-1 -: FIDX_W];

  always_comb begin
    logicCr = crIn;
    logicCr[posT] = newBit;
  end

  // output steering, zero when not produced
  always_comb begin
    resultOut    = '0;
    condFieldOut = '0;
    fullCrOut    = '0;
    if (strobe.readWhole) resultOut = crIn;
    if (strobe.readOne)   resultOut = oneFieldRes;
    if (strobe.moveTo)    fullCrOut = movedCr;
    if (strobe.fieldCopy) begin
      fullCrOut    = copiedCr;
      condFieldOut = copyField;
    end
    if (strobe.bitLogic) begin
      fullCrOut    = logicCr;
      condFieldOut = logicCr[bitSlice*FIELD_BITS +: FIELD_BITS];
    end
  end
endmodule

// File: rtl/cr_field_unit.sv
module cr_field_unit
  import cr_field_unit_pkg::*;
(
  input  logic [OP_W-1:0]       opCode,
  input  logic [INSN_W-1:0]     insnWord,
  input  logic [CR_BITS-1:0]    operandA,
  input  logic [CR_BITS-1:0]    crIn,
  input  logic [NUM_FIELDS-1:0] fieldMask,
  input  logic [FIDX_W-1:0]     dstField,
  input  logic [FIDX_W-1:0]     srcField,
  input  logic [BIDX_W-1:0]     bitT,
  input  logic [BIDX_W-1:0]     bitA,
  input  logic [BIDX_W-1:0]     bitB,
  input  logic [3:0]            truthTab,
  output logic [OP_W-1:0]       opCodeOut,
  output logic [INSN_W-1:0]     insnWordOut,
  output logic [CR_BITS-1:0]    resultOut,
  output logic                  resultValid,
  output logic [FIELD_BITS-1:0] condFieldOut,
  output logic                  condValid,
  output logic [CR_BITS-1:0]    fullCrOut,
  output logic                  fullCrValid
);
  crStrobe_t strobe;

  cr_field_ctrl u_ctrl (
    .opCode   (opCode),
    .insnWord (insnWord),
    .strobe   (strobe)
  );

  cr_field_dp u_dp (
    .strobe       (strobe),
    .operandA     (operandA),
    .crIn         (crIn),
    .fieldMask    (fieldMask),
    .dstField     (dstField),
    .srcField     (srcField),
    .bitT         (bitT),
    .bitA         (bitA),
    .bitB         (bitB),
    .truthTab     (truthTab),
    .resultOut    (resultOut),
    .condFieldOut (condFieldOut),
    .fullCrOut    (fullCrOut)
  );

  assign opCodeOut   = opCode;
  assign insnWordOut = insnWord;
  assign resultValid = strobe.wrResult;
  assign condValid   = strobe.wrCond;
  assign fullCrValid = strobe.wrFull;
endmodule

// File: rtl/cr_field_unit_chk.sv
module cr_field_unit_chk
  import cr_field_unit_pkg::*;
(
  input logic [OP_W-1:0]       opCode,
  input logic [INSN_W-1:0]     insnWord,
  input logic [CR_BITS-1:0]    crIn,
  input logic [NUM_FIELDS-1:0] fieldMask,
  input logic [FIDX_W-1:0]     dstField,
  input logic [BIDX_W-1:0]     bitT,
  input logic [OP_W-1:0]       opCodeOut,
  input logic [INSN_W-1:0]     insnWordOut,
  input logic [CR_BITS-1:0]    resultOut,
  input logic                  resultValid,
  input logic [FIELD_BITS-1:0] condFieldOut,
  input logic                  condValid,
  input logic [CR_BITS-1:0]    fullCrOut,
  input logic                  fullCrValid
);
  always_comb begin
    // R7: a general result never coincides with a condition register write
    a_r7_flags_exclusive: assert (!(resultValid && (condValid || fullCrValid)));
    // R7: a field result always comes with a full register result
    a_r7_cond_implies_full: assert (!condValid || fullCrValid);
    // R8: data outputs without a flag are zero
    a_r8_idle_zero: assert ((resultValid || resultOut == '0) &&
                            (condValid || condFieldOut == '0) &&
                            (fullCrValid || fullCrOut == '0));
    // R9: context passes through untouched
    a_r9_ctx_pass: assert (opCodeOut == opCode && insnWordOut == insnWord);
    // R4: one-field read with a non-single mask yields zero
    a_r4_bad_mask_zero: assert (!(resultValid && insnWord[ONE_FIELD_BIT] &&
                                  $countones(fieldMask) != 1) || resultOut == '0);
    // R3: whole read returns the register
    a_r3_whole_read: assert (!(resultValid && !insnWord[ONE_FIELD_BIT]) ||
                             resultOut == crIn);
    // R5: copy result field agrees with full register at the destination
    a_r5_copy_field: assert (!(condValid && opCode == OP_FIELD_CPY) ||
        condFieldOut == fullCrOut[(FIDX_W'(NUM_FIELDS-1) - dstField)*FIELD_BITS +: FIELD_BITS]);
    // R6: logic result field agrees with full register at the field holding the target bit
    a_r6_logic_field: assert (!(condValid && opCode == OP_BIT_LOGIC) ||
        condFieldOut == fullCrOut[(FIDX_W'(NUM_FIELDS-1) - bitT[BIDX_W-1 -: FIDX_W])*FIELD_BITS +: FIELD_BITS]);
  end
endmodule

bind cr_field_unit cr_field_unit_chk u_chk (
  .opCode       (opCode),
  .insnWord     (insnWord),
  .crIn         (crIn),
  .fieldMask    (fieldMask),
  .dstField     (dstField),
  .bitT         (bitT),
  .opCodeOut    (opCodeOut),
  .insnWordOut  (insnWordOut),
  .resultOut    (resultOut),
  .resultValid  (resultValid),
  .condFieldOut (condFieldOut),
  .condValid    (condValid),
  .fullCrOut    (fullCrOut),
  .fullCrValid  (fullCrValid)
);

// File: tb/cr_field_unit_tb.sv
module cr_field_unit_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic [2:0]  opCode = '0;
  logic [31:0] insnWord = '0, operandA = '0, crIn = '0;
  logic [7:0]  fieldMask = '0;
  logic [2:0]  dstField = '0, srcField = '0;
  logic [4:0]  bitT = '0, bitA = '0, bitB = '0;
  logic [3:0]  truthTab = '0;
  logic [2:0]  opCodeOut;
  logic [31:0] insnWordOut, resultOut, fullCrOut;
  logic [3:0]  condFieldOut;
  logic        resultValid, condValid, fullCrValid;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  cr_field_unit u_dut (
    .opCode(opCode), .insnWord(insnWord), .operandA(operandA), .crIn(crIn),
    .fieldMask(fieldMask), .dstField(dstField), .srcField(srcField),
    .bitT(bitT), .bitA(bitA), .bitB(bitB), .truthTab(truthTab),
    .opCodeOut(opCodeOut), .insnWordOut(insnWordOut),
    .resultOut(resultOut), .resultValid(resultValid),
    .condFieldOut(condFieldOut), .condValid(condValid),
    .fullCrOut(fullCrOut), .fullCrValid(fullCrValid)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference, evaluated for the current inputs
  task automatic compare_all();
    logic [31:0] eRes, eFull;
    logic [3:0]  eCond;
    logic        eRv, eCv, eFv;
    int          cnt;
    int          pos;
    int          tf;
    eRes = '0; eFull = '0; eCond = '0; eRv = 0; eCv = 0; eFv = 0;
    case (opCode)
      3'd1: begin // R2
        eFv = 1;
        for (int j = 0; j < 32; j++)
          eFull[j] = fieldMask[j/4] ? operandA[j] : crIn[j];
      end
      3'd2: begin
        eRv = 1;
        if (!insnWord[20]) eRes = crIn; // R3
        else begin // R4
          cnt = 0;
          for (int k = 0; k < 8; k++) if (fieldMask[k]) cnt++;
          for (int j = 0; j < 32; j++)
            eRes[j] = (cnt == 1 && fieldMask[j/4]) ? crIn[j] : 1'b0;
        end
      end
      3'd3: begin // R5
        eFv = 1; eCv = 1;
        for (int j = 0; j < 32; j++)
          eFull[j] = (j/4 == 7 - int'(dstField)) ? crIn[(7 - int'(srcField))*4 + j%4] : crIn[j];
        for (int j = 0; j < 4; j++) eCond[j] = crIn[(7 - int'(srcField))*4 + j];
      end
      3'd4: begin // R6
        eFv = 1; eCv = 1;
        pos = 31 - int'(bitT);
        eFull = crIn;
        eFull[pos] = truthTab[2*int'(crIn[31-int'(bitA)]) + int'(crIn[31-int'(bitB)])];
        tf = pos / 4;
        for (int j = 0; j < 4; j++) eCond[j] = eFull[tf*4 + j];
      end
      default: ; // R1: no operation, R8 zero outputs
    endcase
    check("R7 resultValid", {31'b0, resultValid}, {31'b0, eRv});
    check("R7 condValid",   {31'b0, condValid},   {31'b0, eCv});
    check("R7 fullCrValid", {31'b0, fullCrValid}, {31'b0, eFv});
    check("R10/R8 resultOut", resultOut, eRes);
    check("R10/R8 condFieldOut", {28'b0, condFieldOut}, {28'b0, eCond});
    check("R10/R8 fullCrOut", fullCrOut, eFull);
    check("R9 opCodeOut", {29'b0, opCodeOut}, {29'b0, opCode});
    check("R9 insnWordOut", insnWordOut, insnWord);
  endtask

  task automatic step();
    #2;
    compare_all();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // reset / idle state: every output zero (R8)
    compare_all();
    rst = 1'b0;

    crIn = 32'h1234_5678; operandA = 32'hFEDC_BA98;
    // R2 empty and full masks
    opCode = 3'd1; fieldMask = 8'h00; step();
    fieldMask = 8'hFF; step();
    fieldMask = 8'h5A; step();
    // R3 whole read
    opCode = 3'd2; insnWord = 32'h0; step();
    // R4 one-field: single, none, two
    insnWord = 32'h0010_0000; fieldMask = 8'h80; step();
    fieldMask = 8'h00; step();
    fieldMask = 8'h11; step();
    fieldMask = 8'h01; step();
    // R5 copy, including onto itself
    opCode = 3'd3; dstField = 3'd0; srcField = 3'd7; step();
    dstField = 3'd4; srcField = 3'd4; step();
    // R6 logic: target equals a source, AND/OR/XOR tables
    opCode = 3'd4; bitT = 5'd3; bitA = 5'd3; bitB = 5'd30; truthTab = 4'b1000; step();
    bitT = 5'd31; bitA = 5'd0; bitB = 5'd1; truthTab = 4'b1110; step();
    bitT = 5'd0; truthTab = 4'b0110; step();
    // R1 unused codes are no-ops
    for (int c = 5; c < 8; c++) begin opCode = 3'(c); step(); end
    opCode = 3'd0; step();

    // random sweep across all codes
    for (int n = 0; n < 2000; n++) begin
      opCode    = 3'($urandom_range(0, 7));
      insnWord  = $urandom();
      operandA  = $urandom();
      crIn      = $urandom();
      fieldMask = ($urandom_range(0, 1) == 1) ? 8'(1 << $urandom_range(0, 7)) : 8'($urandom());
      dstField  = 3'($urandom());
      srcField  = 3'($urandom());
      bitT      = 5'($urandom());
      bitA      = 5'($urandom());
      bitB      = 5'($urandom());
      truthTab  = 4'($urandom());
      step();
    end
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule